// File: doc/BRIEF.md
# Packed-Instruction Accumulator Processor

This block is a small accumulator processor core with its own 1024-word, 32-bit memory. It has a 32-bit accumulator, a 32-bit index register, a 10-bit word program counter and a flag that selects which half of the current word holds the next instruction. Each 32-bit memory word carries two 16-bit instructions. The core fetches them in turn, forms an effective address in one of four index modes and executes one of 26 operations. Characters move in and out over one byte-wide valid/ready channel in each direction.

A separate loader fills memory through the external port while the core is idle or stopped. It then pulses `run` with a start word address. The core runs until it meets a halt or an undefined system code, and then raises `halted`. The loader can then read results back over the same port.

The controller has seven named states:
- `S_IDLE`: after reset.
- `S_FETCH`: reads the word at the program counter.
- `S_DECODE`: picks the half-word, forms the address, and executes register, store and branch operations.
- `S_OPER`: finishes operations that read a memory operand.
- `S_RXWAIT`: waits for an input byte.
- `S_TXWAIT`: waits for the output byte to be accepted.
- `S_STOP`: halted.

The transitions are:
- run: `S_IDLE`/`S_STOP` → `S_FETCH`
- fetch: `S_FETCH` → `S_DECODE`
- done: `S_DECODE` → `S_FETCH`
- operand: `S_DECODE` → `S_OPER`
- input: `S_DECODE` → `S_RXWAIT`
- output: `S_DECODE` → `S_TXWAIT`
- stop: `S_DECODE` → `S_STOP`
- complete: `S_OPER`/`S_RXWAIT`/`S_TXWAIT` → `S_FETCH`

Top module: `pkc_core`

## Requirements
- R1: After reset the core is idle: `halted`=0, `error`=0, `tx_valid`=0, `rx_ready`=0.
- R2: An instruction is 16 bits: opcode in bits 15:12, mode in bits 11:10, address field in bits 9:0. The half in bits 15:0 of a word executes before the half in bits 31:16. After the upper half, the program counter steps by one word and the half flag clears.
- R3: The program counter and every effective address keep only their low 10 bits, so execution continues from word 1023 to word 0.
- R4: Mode 0 uses the field as the address. Mode 1 uses field+XR. Mode 2 uses field+XR and then adds one to XR. Mode 3 subtracts one from XR and then uses field+XR. XR updates are full 32-bit. Opcode 0 ignores the mode.
- R5: Opcode 2 loads AC from memory. Opcodes 6, 7, 8 and 9 combine AC with the memory word by add, subtract, OR and AND.
- R6: With opcode 0, field codes 1, 2, 3 and 4 negate AC, invert AC, shift AC left one place and shift AC right one place (logical). Codes 8, 9 and 10 do nothing.
- R7: Opcode 1 puts the zero-extended effective address into AC. Opcode 3 stores AC, opcode 4 loads XR from memory, and opcode 5 stores XR.
- R8: Opcode 10 adds one to the addressed memory word and opcode 11 subtracts one from it, both modulo 2^32.
- R9: Opcode 12 always branches, opcode 13 branches when AC is zero and opcode 14 branches when AC bit 31 is set. A branch loads the effective address into the program counter and resumes at the lower half.
- R10: Opcode 15 copies the word address of the current instruction into XR, then branches.
- R11: System code 5 holds `rx_ready` high until a byte is offered, then places the byte zero-extended in AC.
- R12: System code 6 sends AC bits 7:0 and code 7 sends 0x0A. `tx_valid` and `tx_data` hold steady until `tx_ready`.
- R13: System code 0 stops with `error`=0. Codes above 10 stop with `error`=1. A stopped core stays stopped until `run`, which clears `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start pulse, accepted when idle or stopped |
| start_pc | input | 10 | Start word address taken on `run` |
| ext_we | input | 1 | Loader write enable, honoured only when idle or stopped |
| ext_addr | input | 10 | Loader word address |
| ext_wdata | input | 32 | Loader write data |
| ext_rdata | output | 32 | Loader read data, one cycle after the address |
| rx_valid | input | 1 | Input byte offered |
| rx_data | input | 8 | Input byte |
| rx_ready | output | 1 | Core waiting for input |
| tx_valid | output | 1 | Output byte offered |
| tx_data | output | 8 | Output byte |
| tx_ready | input | 1 | Output byte accepted |
| halted | output | 1 | Core stopped |
| error | output | 1 | Stop was caused by an undefined system code |

## Verification
Register-only, store and branch instructions take two cycles (fetch, then decode). Operations that read memory take three cycles. Input and output instructions stay in their wait state until the handshake edge, then continue on the next cycle. `ext_rdata` is due one edge after the address is applied.

The checks do not count cycles inside a program. Each program ends in a halt, and the bench waits for `halted`. It then reads the stored results through the loader port, sampling at the falling edge after the read edge. The output channel is sampled at falling edges, where a handshake is seen as `tx_valid` and `tx_ready` both high ahead of the next rising edge.

// File: rtl/pkc_pkg.sv
package pkc_pkg;
    localparam int WORD_W  = 32;
    localparam int PADDR_W = 10;
    localparam int INSN_W  = 16;

    typedef enum logic [3:0] {
        OP_SYS = 4'd0,  OP_LIT = 4'd1,  OP_LDA = 4'd2,  OP_STA = 4'd3,
        OP_LDX = 4'd4,  OP_STX = 4'd5,  OP_ADD = 4'd6,  OP_SUB = 4'd7,
        OP_OR  = 4'd8,  OP_AND = 4'd9,  OP_INC = 4'd10, OP_DEC = 4'd11,
        OP_JMP = 4'd12, OP_JPZ = 4'd13, OP_JPN = 4'd14, OP_JSR = 4'd15
    } opc_e;

    localparam logic [9:0] SYS_HALT = 10'd0;
    localparam logic [9:0] SYS_NEG  = 10'd1;
    localparam logic [9:0] SYS_COM  = 10'd2;
    localparam logic [9:0] SYS_SHL  = 10'd3;
    localparam logic [9:0] SYS_SHR  = 10'd4;
    localparam logic [9:0] SYS_READ = 10'd5;
    localparam logic [9:0] SYS_WRT  = 10'd6;
    localparam logic [9:0] SYS_NEWL = 10'd7;
    localparam logic [9:0] SYS_LAST = 10'd10;

    typedef struct packed {
        opc_e       opc;
        logic [1:0] mode;
        logic [9:0] field;
    } insn_t;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_OPER, S_RXWAIT, S_TXWAIT, S_STOP
    } state_e;
endpackage

// File: rtl/pkc_mem.sv
module pkc_mem #(
    parameter int DATA_W = 32,
    parameter int AW     = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end
endmodule

// File: rtl/pkc_addr_gen.sv
module pkc_addr_gen #(
    parameter int DATA_W = 32,
    parameter int AW     = 10
) (
    input  logic [1:0]        mode,
    input  logic [AW-1:0]     field,
    input  logic [DATA_W-1:0] xr,
    output logic [AW-1:0]     ea,
    output logic [DATA_W-1:0] xr_next,
    output logic              xr_upd
);
    always_comb begin
        xr_next = xr;
        xr_upd  = 1'b0;
        ea      = field;
        unique case (mode)
            2'd0: ea = field;
            2'd1: ea = field + xr[AW-1:0];
            2'd2: begin
                ea      = field + xr[AW-1:0];
                xr_next = xr + 1'b1;
                xr_upd  = 1'b1;
            end
            2'd3: begin
                xr_next = xr - 1'b1;
                ea      = field + xr_next[AW-1:0];
                xr_upd  = 1'b1;
            end
            default: ea = field;
        endcase
    end
endmodule

// File: rtl/pkc_alu.sv
module pkc_alu
    import pkc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opc_e              opc,
    input  logic [9:0]        sys_fn,
    input  logic [DATA_W-1:0] ac,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        res = ac;
        unique case (opc)
            OP_SYS: begin
                if (sys_fn == SYS_NEG)      res = -ac;
                else if (sys_fn == SYS_COM) res = ~ac;
                else if (sys_fn == SYS_SHL) res = ac << 1;
                else if (sys_fn == SYS_SHR) res = ac >> 1;
                else                        res = ac;
            end
            OP_LDA:  res = opnd;
            OP_ADD:  res = ac + opnd;
            OP_SUB:  res = ac - opnd;
            OP_OR:   res = ac | opnd;
            OP_AND:  res = ac & opnd;
            OP_INC:  res = opnd + 1'b1;
            OP_DEC:  res = opnd - 1'b1;
            default: res = ac;
        endcase
    end
endmodule

// File: rtl/pkc_core.sv
module pkc_core
    import pkc_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int AW     = PADDR_W,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [AW-1:0]     start_pc,
    input  logic              ext_we,
    input  logic [AW-1:0]     ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    output logic [DATA_W-1:0] ext_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              halted,
    output logic              error
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [BYTE_W-1:0] LINE_FEED = BYTE_W'(8'h0A);

    state_e            state_q, state_d;
    logic [AW-1:0]     pc_q, ea_q;
    logic              pchi_q, err_q;
    logic [DATA_W-1:0] ac_q, xr_q;
    opc_e              ir_opc_q;
    logic [BYTE_W-1:0] txb_q;

    logic              mem_we;
    logic [AW-1:0]     mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [HALF_W-1:0] half;
    insn_t             cur;
    logic [AW-1:0]     ea;
    logic [DATA_W-1:0] xr_next, alu_res;
    logic              xr_upd;
    opc_e              alu_opc;
    logic              needs_opnd, is_stop, take_br;

    pkc_mem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    assign half = pchi_q ? mem_rdata[DATA_W-1:HALF_W] : mem_rdata[HALF_W-1:0];
    assign cur  = insn_t'(half);

    pkc_addr_gen #(.DATA_W(DATA_W), .AW(AW)) u_agen (
        .mode(cur.mode), .field(cur.field), .xr(xr_q),
        .ea(ea), .xr_next(xr_next), .xr_upd(xr_upd)
    );

    assign alu_opc = (state_q == S_OPER) ? ir_opc_q : cur.opc;

    pkc_alu #(.DATA_W(DATA_W)) u_alu (
        .opc(alu_opc), .sys_fn(cur.field), .ac(ac_q),
        .opnd(mem_rdata), .res(alu_res)
    );

    always_comb begin
        needs_opnd = cur.opc inside {OP_LDA, OP_LDX, OP_ADD, OP_SUB, OP_OR,
                                     OP_AND, OP_INC, OP_DEC};
        is_stop    = (cur.opc == OP_SYS) &&
                     ((cur.field == SYS_HALT) || (cur.field > SYS_LAST));
        unique case (cur.opc)
            OP_JMP, OP_JSR: take_br = 1'b1;
            OP_JPZ:         take_br = (ac_q == '0);
            OP_JPN:         take_br = ac_q[DATA_W-1];
            default:        take_br = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_STOP: if (run) state_d = S_FETCH;
            S_FETCH:        state_d = S_DECODE;
            S_DECODE: begin
                if (is_stop)                                          state_d = S_STOP;
                else if (cur.opc == OP_SYS && cur.field == SYS_READ)  state_d = S_RXWAIT;
                else if (cur.opc == OP_SYS &&
                         (cur.field == SYS_WRT || cur.field == SYS_NEWL)) state_d = S_TXWAIT;
                else if (needs_opnd)                                  state_d = S_OPER;
                else                                                  state_d = S_FETCH;
            end
            S_OPER:         state_d = S_FETCH;
            S_RXWAIT:       if (rx_valid) state_d = S_FETCH;
            S_TXWAIT:       if (tx_ready) state_d = S_FETCH;
            default:        state_d = S_IDLE;
        endcase
    end

    // architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            pchi_q   <= 1'b0;
            ac_q     <= '0;
            xr_q     <= '0;
            ea_q     <= '0;
            err_q    <= 1'b0;
            txb_q    <= '0;
            ir_opc_q <= OP_SYS;
        end else begin
            unique case (state_q)
                S_IDLE, S_STOP: begin
                    if (run) begin
                        pc_q   <= start_pc;
                        pchi_q <= 1'b0;
                        err_q  <= 1'b0;
                    end
                end
                S_DECODE: begin
                    ir_opc_q <= cur.opc;
                    ea_q     <= ea;
                    if (cur.opc == OP_SYS) begin
                        if (cur.field > SYS_LAST) begin
                            err_q <= 1'b1;
                        end else if (cur.field == SYS_WRT) begin
                            txb_q <= ac_q[BYTE_W-1:0];
                        end else if (cur.field == SYS_NEWL) begin
                            txb_q <= LINE_FEED;
                        end else if (cur.field != SYS_HALT && cur.field != SYS_READ) begin
                            ac_q <= alu_res;
                            if (pchi_q) begin pc_q <= pc_q + 1'b1; pchi_q <= 1'b0; end
                            else        pchi_q <= 1'b1;
                        end
                    end else begin
                        if (xr_upd) xr_q <= xr_next;
                        if (cur.opc == OP_LIT) ac_q <= DATA_W'(ea);
                        if (cur.opc == OP_JSR) xr_q <= DATA_W'(pc_q);
                        if (take_br) begin
                            pc_q   <= ea;
                            pchi_q <= 1'b0;
                        end else if (!needs_opnd) begin
                            if (pchi_q) begin pc_q <= pc_q + 1'b1; pchi_q <= 1'b0; end
                            else        pchi_q <= 1'b1;
                        end
                    end
                end
                S_OPER: begin
                    if (ir_opc_q == OP_LDX)                           xr_q <= mem_rdata;
                    else if (ir_opc_q != OP_INC && ir_opc_q != OP_DEC) ac_q <= alu_res;
                    if (pchi_q) begin pc_q <= pc_q + 1'b1; pchi_q <= 1'b0; end
                    else        pchi_q <= 1'b1;
                end
                S_RXWAIT: begin
                    if (rx_valid) begin
                        ac_q <= DATA_W'(rx_data);
                        if (pchi_q) begin pc_q <= pc_q + 1'b1; pchi_q <= 1'b0; end
                        else        pchi_q <= 1'b1;
                    end
                end
                S_TXWAIT: begin
                    if (tx_ready) begin
                        if (pchi_q) begin pc_q <= pc_q + 1'b1; pchi_q <= 1'b0; end
                        else        pchi_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs and memory port
    always_comb begin
        mem_addr  = ext_addr;
        mem_wdata = ext_wdata;
        mem_we    = 1'b0;
        unique case (state_q)
            S_IDLE, S_STOP: mem_we = ext_we;
            S_FETCH:        mem_addr = pc_q;
            S_DECODE: begin
                mem_addr  = ea;
                mem_we    = (cur.opc == OP_STA) || (cur.opc == OP_STX);
                mem_wdata = (cur.opc == OP_STX) ? xr_q : ac_q;
            end
            S_OPER: begin
                mem_addr  = ea_q;
                mem_we    = (ir_opc_q == OP_INC) || (ir_opc_q == OP_DEC);
                mem_wdata = alu_res;
            end
            default:        mem_addr = pc_q;
        endcase
        ext_rdata = mem_rdata;
        rx_ready  = (state_q == S_RXWAIT);
        tx_valid  = (state_q == S_TXWAIT);
        tx_data   = txb_q;
        halted    = (state_q == S_STOP);
        error     = err_q;
    end

    assert_half_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pchi_q) |-> $stable(pc_q));
    assert_err_stopped_R13: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> halted);
    assert_stop_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !run) |=> halted);
    assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    assert_rx_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rx_valid) |=> rx_ready);
endmodule

// File: tb/pkc_core_tb.sv
module pkc_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [9:0]  start_pc = '0;
    logic        ext_we = 1'b0;
    logic [9:0]  ext_addr = '0;
    logic [31:0] ext_wdata = '0;
    logic [31:0] ext_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, tx_ready, halted, error;
    logic [7:0]  tx_data;

    int checks = 0, fails = 0;
    int tx_stall = 0, tx_n = 0;
    logic [7:0] tx_buf [8];

    always #10 clk = ~clk;

    pkc_core u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .start_pc(start_pc),
        .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .halted(halted), .error(error)
    );

    // output channel sink: readiness decided and handshake recorded at falling edges
    initial begin
        tx_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (tx_stall > 0) begin tx_ready = 1'b0; tx_stall--; end
            else              tx_ready = 1'b1;
            if (tx_valid && tx_ready && tx_n < 8) begin
                tx_buf[tx_n] = tx_data;
                tx_n++;
            end
        end
    end

    function automatic logic [15:0] ins(int op, int md, int adr);
        return {op[3:0], md[1:0], adr[9:0]};
    endfunction

    function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b);
        case (op)
            6: return a + b;
            7: return a - b;
            8: return a | b;
            default: return a & b;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        ext_we = 1'b1; ext_addr = a[9:0]; ext_wdata = d;
        @(negedge clk);
        ext_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        ext_addr = a[9:0];
        @(negedge clk);
        d = ext_rdata;
    endtask

    task automatic put(int w, logic [15:0] lo, logic [15:0] hi);
        wr(w, {hi, lo});
    endtask

    task automatic go(int pc);
        @(negedge clk);
        run = 1'b1; start_pc = pc[9:0];
        @(negedge clk);
        run = 1'b0;
        for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
    endtask

    task automatic expect_mem(string req, int a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] a, b, v;
        int op;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 halted", {31'd0, halted}, 32'd0);
        check("R1 error", {31'd0, error}, 32'd0);
        check("R1 handshakes", {30'd0, tx_valid, rx_ready}, 32'd0);

        // R5 R2: random operand pairs, operation in the upper half of word 0
        for (int k = 0; k < 6; k++) begin
            a = $urandom; b = $urandom; op = 6 + int'($urandom % 4);
            if (k == 0) begin a = 32'hFFFF_FFFF; b = 32'd1; op = 6; end
            wr(100, a); wr(101, b);
            put(0, ins(2, 0, 100), ins(op, 0, 101));
            put(1, ins(3, 0, 200), ins(0, 0, 0));
            go(0);
            expect_mem("R5 alu", 200, model(op, a, b));
        end
        check("R13 halt no error", {30'd0, halted, error}, 32'd2);

        // R6 R7 system register operations
        put(0, ins(1, 0, 'h3F5), ins(0, 0, 1));
        put(1, ins(3, 0, 200), ins(0, 0, 4));
        put(2, ins(3, 0, 201), ins(0, 0, 2));
        put(3, ins(3, 0, 202), ins(0, 0, 3));
        put(4, ins(3, 0, 203), ins(0, 0, 9));
        put(5, ins(0, 0, 8), ins(0, 0, 0));
        go(0);
        expect_mem("R6 neg", 200, 32'hFFFF_FC0B);
        expect_mem("R6 shr logical", 201, 32'h7FFF_FE05);
        expect_mem("R6 com", 202, 32'h8000_01FA);
        expect_mem("R6 shl", 203, 32'h0000_03F4);

        // R4 R7 index modes
        wr(300, 32'd10); wr(50, 32'hAAAA); wr(51, 32'hBBBB); wr(49, 32'hCCCC);
        put(0, ins(4, 0, 300), ins(2, 2, 40));
        put(1, ins(3, 0, 210), ins(2, 2, 40));
        put(2, ins(3, 0, 211), ins(2, 3, 40));
        put(3, ins(3, 0, 212), ins(2, 1, 38));
        put(4, ins(3, 0, 213), ins(5, 0, 214));
        put(5, ins(0, 0, 0), ins(0, 0, 0));
        go(0);
        expect_mem("R4 mode2", 210, 32'hAAAA);
        expect_mem("R4 mode2 again", 211, 32'hBBBB);
        expect_mem("R4 mode3", 212, 32'hBBBB);
        expect_mem("R4 mode1", 213, 32'hCCCC);
        expect_mem("R7 stx", 214, 32'd11);

        // R9 R10 branches
        wr(220, 32'h55); wr(222, 32'h0);
        put(0, ins(1, 0, 0), ins(13, 0, 4));
        put(1, ins(1, 0, 7), ins(3, 0, 220));
        put(4, ins(1, 0, 1), ins(13, 0, 6));
        put(5, ins(3, 0, 222), ins(0, 0, 1));
        put(6, ins(14, 0, 8), ins(1, 0, 9));
        put(8, ins(15, 0, 10), ins(0, 0, 11));
        put(10, ins(5, 0, 221), ins(0, 0, 0));
        go(0);
        expect_mem("R9 skipped store", 220, 32'h55);
        expect_mem("R9 jpz not taken", 222, 32'd1);
        expect_mem("R10 jsr link", 221, 32'd8);
        check("R9 path", {30'd0, halted, error}, 32'd2);

        // R8 R3 memory step and wrap from word 1023
        wr(230, 32'hFFFF_FFFF); wr(231, 32'd0);
        put(1023, ins(10, 0, 230), ins(11, 0, 231));
        put(0, ins(0, 0, 0), ins(0, 0, 0));
        go(1023);
        expect_mem("R8 inc", 230, 32'd0);
        expect_mem("R8 dec", 231, 32'hFFFF_FFFF);
        check("R3 wrap halt", {30'd0, halted, error}, 32'd2);

        // R11 R12 byte channels
        put(0, ins(0, 0, 5), ins(3, 0, 240));
        put(1, ins(0, 0, 6), ins(0, 0, 7));
        put(2, ins(1, 0, 'h141), ins(0, 0, 6));
        put(3, ins(0, 0, 0), ins(0, 0, 0));
        tx_n = 0;
        @(negedge clk);
        run = 1'b1; start_pc = '0;
        @(negedge clk);
        run = 1'b0;
        repeat (15) @(negedge clk);
        check("R11 stall", {30'd0, halted, rx_ready}, 32'd1);
        tx_stall = 6;
        rx_valid = 1'b1; rx_data = 8'h5A;
        for (int i = 0; i < 50; i++) begin
            if (rx_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
        expect_mem("R11 zero extend", 240, 32'h5A);
        check("R12 count", tx_n, 3);
        check("R12 wrt", {24'd0, tx_buf[0]}, 32'h5A);
        check("R12 newl", {24'd0, tx_buf[1]}, 32'h0A);
        check("R12 low byte", {24'd0, tx_buf[2]}, 32'h41);

        // R13 undefined system code
        put(0, ins(0, 3, 11), ins(0, 0, 0));
        go(0);
        check("R13 invalid stop", {30'd0, halted, error}, 32'd3);
        put(0, ins(0, 0, 0), ins(0, 0, 0));
        go(0);
        check("R13 error cleared", {30'd0, halted, error}, 32'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule